// File: doc/BRIEF.md
# Decoded Event Serial Output Formatter

This block turns an accepted remote-control event, or the result of a learn attempt, into one short 10-bit report frame. A host controller with few spare pins reads the frame from the formatter's output lines. A one-cycle strobe starts the frame. At that moment a kind select picks one of two payload layouts and the formatter captures all payload inputs. The formatter then sequences the ten bits onto the output lines and holds a busy flag high for the whole frame.

Two signalling styles are supported, and a mode input chooses between them when the frame starts:

- **One-wire style.** Each bit is a self-clocked pulse-width symbol three elements long, sent on the data line only.
- **Two-wire style.** Each bit is sent with a companion clock line. The data line changes together with the clock's rising edge, and the receiver samples it on the falling edge.

One element is `ELEM_CYCLES` system clock cycles long. The default of 80000 gives 400 µs at 200 MHz.

Top module: `evt_serial_fmt`

## Requirements
- R1: With `kind_i`=0 (event), the bits go out in this order: 1, `func_i[3]`, `func_i[2]`, `func_i[1]`, `func_i[0]`, `lowbat_i`, `repeat_i`, `txcnt_i[1]`, `txcnt_i[0]`, 1. `txcnt_i` carries the number of learned transmitters minus one (00 = one, 11 = four).
- R2: With `kind_i`=1 (learn status), the bits go out in this order: 1, 0, 0, 0, 0, `result_i`, `ovwr_i`, `txcnt_i[1]`, `txcnt_i[0]`, 1.
- R3: The first and the last bit of every frame are 1 in both layouts and both modes.
- R4: With `sync_mode_i`=0 (one-wire), a 1 bit is one element high followed by two elements low. A 0 bit is two elements high followed by one element low. Each element lasts exactly `ELEM_CYCLES` cycles, and `clk_o` stays low for the whole frame.
- R5: With `sync_mode_i`=1 (two-wire), each bit lasts two elements. `clk_o` is high for the first element and low for the second. `data_o` takes the bit value as `clk_o` rises and holds it for the whole bit.
- R6: The frame's first element appears in the first cycle after the clock edge that accepts `send_i`. `busy_o` is high for exactly 30·`ELEM_CYCLES` cycles in one-wire mode and 20·`ELEM_CYCLES` cycles in two-wire mode.
- R7: A `send_i` pulse while `busy_o` is high is ignored. This includes the last cycle of a frame: the running frame is unchanged, and no further frame follows it.
- R8: After reset and between frames, `data_o`, `clk_o` and `busy_o` are all low.
- R9: Payload inputs, `kind_i` and `sync_mode_i` are captured when `send_i` is accepted. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| send_i | input | 1 | Start-frame strobe |
| kind_i | input | 1 | 0 = event layout, 1 = learn-status layout |
| func_i | input | 4 | Function bits, bit 3 sent first |
| lowbat_i | input | 1 | Low-battery flag (event layout) |
| repeat_i | input | 1 | Repeated-transmission flag (event layout) |
| txcnt_i | input | 2 | Learned transmitter count minus one |
| result_i | input | 1 | Learn succeeded flag (status layout) |
| ovwr_i | input | 1 | Learn overwrote a slot flag (status layout) |
| sync_mode_i | input | 1 | 0 = one-wire pulse width, 1 = two-wire clocked |
| data_o | output | 1 | Serial data line |
| clk_o | output | 1 | Serial clock line (two-wire mode only) |
| busy_o | output | 1 | High while a frame is being sent |

## Verification
The bench compares `data_o`, `clk_o` and `busy_o` against an independently built waveform in every cycle of each frame. It covers both layouts in both modes, including all-zero and all-one payloads. A design with the wrong bit order or mixed-up layouts, or with inverted pulse-width symbols, would show the wrong level within a single element. During each frame the bench changes every payload and mode input and fires `send_i`, and it fires `send_i` again in the frame's last busy cycle. A design that re-captured inputs or restarted would show changed data or a second frame in the idle window that follows. An element counter that is off by one would stretch or shrink `busy_o`, and the exact-length check catches this at the frame's end.

// File: rtl/efmt_pkg.sv
package efmt_pkg;
    localparam int FRAME_BITS = 10;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    typedef enum logic {
        KIND_EVENT  = 1'b0,
        KIND_STATUS = 1'b1
    } kind_e;

    typedef enum logic {
        MODE_PWM  = 1'b0,
        MODE_SYNC = 1'b1
    } line_mode_e;

    // Element slot within one bit: A first, C only used by pulse-width mode
    typedef enum logic [1:0] {
        PH_A = 2'd0,
        PH_B = 2'd1,
        PH_C = 2'd2
    } phase_e;
endpackage

// File: rtl/efmt_frame_build.sv
module efmt_frame_build
    import efmt_pkg::*;
(
    input  kind_e                 kind_i,
    input  logic [3:0]            func_i,
    input  logic                  lowbat_i,
    input  logic                  repeat_i,
    input  logic [1:0]            txcnt_i,
    input  logic                  result_i,
    input  logic                  ovwr_i,
    output logic [FRAME_BITS-1:0] frame_o   // bit 0 goes out first
);
    logic [1:0] flags;

    always_comb begin
        flags = (kind_i == KIND_STATUS) ? {result_i, ovwr_i} : {lowbat_i, repeat_i};
        frame_o    = '0;
        frame_o[0] = 1'b1;                                   // start
        frame_o[4:1] = (kind_i == KIND_STATUS) ? 4'b0000
                       : {func_i[0], func_i[1], func_i[2], func_i[3]};
        frame_o[5] = flags[1];
        frame_o[6] = flags[0];
        frame_o[7] = txcnt_i[1];
        frame_o[8] = txcnt_i[0];
        frame_o[FRAME_BITS-1] = 1'b1;                        // stop
    end
endmodule

// File: rtl/efmt_elem_timer.sv
module efmt_elem_timer #(
    parameter int ELEM_CYCLES = 80000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CNT_W = (ELEM_CYCLES > 1) ? $clog2(ELEM_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ELEM_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        tick_o = run_i && (cnt_q == LAST);
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R6
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0);
endmodule

// File: rtl/efmt_line_enc.sv
module efmt_line_enc
    import efmt_pkg::*;
(
    input  logic       active_i,
    input  line_mode_e mode_i,
    input  phase_e     phase_i,
    input  logic       bit_i,
    output logic       data_o,
    output logic       clk_o
);
    always_comb begin
        data_o = 1'b0;
        clk_o  = 1'b0;
        if (active_i) begin
            if (mode_i == MODE_SYNC) begin
                data_o = bit_i;
                clk_o  = (phase_i == PH_A);
            end else begin
                unique case (phase_i)
                    PH_A:    data_o = 1'b1;
                    PH_B:    data_o = ~bit_i;
                    default: data_o = 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/evt_serial_fmt.sv
module evt_serial_fmt
    import efmt_pkg::*;
#(
    parameter int ELEM_CYCLES = 80000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       send_i,
    input  logic       kind_i,
    input  logic [3:0] func_i,
    input  logic       lowbat_i,
    input  logic       repeat_i,
    input  logic [1:0] txcnt_i,
    input  logic       result_i,
    input  logic       ovwr_i,
    input  logic       sync_mode_i,
    output logic       data_o,
    output logic       clk_o,
    output logic       busy_o
);
    localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic                  busy;
        line_mode_e            mode;
        logic [IDX_W-1:0]      bit_idx;
        phase_e                phase;
        logic [FRAME_BITS-1:0] frame;
    } seq_t;

    seq_t                  s_d, s_q;
    logic                  tick;
    logic [FRAME_BITS-1:0] built;
    phase_e                last_phase;

    efmt_frame_build build_i (
        .kind_i   (kind_e'(kind_i)),
        .func_i   (func_i),
        .lowbat_i (lowbat_i),
        .repeat_i (repeat_i),
        .txcnt_i  (txcnt_i),
        .result_i (result_i),
        .ovwr_i   (ovwr_i),
        .frame_o  (built)
    );

    efmt_elem_timer #(.ELEM_CYCLES(ELEM_CYCLES)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (s_q.busy),
        .tick_o (tick)
    );

    efmt_line_enc enc_i (
        .active_i (s_q.busy),
        .mode_i   (s_q.mode),
        .phase_i  (s_q.phase),
        .bit_i    (s_q.frame[s_q.bit_idx]),
        .data_o   (data_o),
        .clk_o    (clk_o)
    );

    always_comb begin
        s_d        = s_q;
        last_phase = (s_q.mode == MODE_SYNC) ? PH_B : PH_C;
        if (!s_q.busy) begin
            if (send_i) begin
                s_d.busy    = 1'b1;
                s_d.mode    = line_mode_e'(sync_mode_i);
                s_d.bit_idx = '0;
                s_d.phase   = PH_A;
                s_d.frame   = built;
            end
        end else if (tick) begin
            if (s_q.phase == last_phase) begin
                s_d.phase = PH_A;
                if (s_q.bit_idx == LAST_BIT) s_d.busy = 1'b0;
                else                         s_d.bit_idx = s_q.bit_idx + 1'b1;
            end else begin
                s_d.phase = phase_e'(s_q.phase + 2'd1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.busy    <= 1'b0;
            s_q.mode    <= MODE_PWM;
            s_q.bit_idx <= '0;
            s_q.phase   <= PH_A;
            s_q.frame   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = s_q.busy;

    // R8
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!data_o && !clk_o));

    // R3
    start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> data_o);

    // R4
    pwm_no_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && s_q.mode == MODE_PWM) |-> !clk_o);

    // R4
    pwm_tail_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && s_q.mode == MODE_PWM && s_q.phase == PH_C) |-> !data_o);

    // R5
    sync_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && s_q.mode == MODE_SYNC && !$rose(clk_o))
            |-> $stable(data_o));

    // R7
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(s_q.frame) && $stable(s_q.mode)));

    // R6
    no_early_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |=> busy_o);
endmodule

// File: tb/evt_serial_fmt_tb_top.sv
module evt_serial_fmt_tb_top;
    localparam int ELEM = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       send_i, kind_i, lowbat_i, repeat_i, result_i, ovwr_i, sync_mode_i;
    logic [3:0] func_i;
    logic [1:0] txcnt_i;
    logic       data_o, clk_o, busy_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    evt_serial_fmt #(.ELEM_CYCLES(ELEM)) dut_i (
        .clk(clk), .rst_n(rst_n), .send_i(send_i), .kind_i(kind_i),
        .func_i(func_i), .lowbat_i(lowbat_i), .repeat_i(repeat_i),
        .txcnt_i(txcnt_i), .result_i(result_i), .ovwr_i(ovwr_i),
        .sync_mode_i(sync_mode_i), .data_o(data_o), .clk_o(clk_o),
        .busy_o(busy_o)
    );

    task automatic chk(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", what, act, exp, $time);
        end
    endtask

    task automatic check_reset();
        rst_n = 1'b0; send_i = 0; kind_i = 0; func_i = 0; lowbat_i = 0;
        repeat_i = 0; txcnt_i = 0; result_i = 0; ovwr_i = 0; sync_mode_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(data_o, 1'b0, "R8 reset data");
        chk(clk_o,  1'b0, "R8 reset clk");
        chk(busy_o, 1'b0, "R8 reset busy");
    endtask

    // Sends one frame, checks every cycle, disturbs inputs mid-frame.
    task automatic run_frame(input logic kd, input logic [3:0] fn, input logic lb,
                             input logic rp, input logic [1:0] tx, input logic res,
                             input logic ov, input logic md, input string tag);
        logic exp_bits [10];
        int   nph;
        int   cyc;
        logic ed, ec;
        exp_bits[0] = 1'b1;
        exp_bits[9] = 1'b1;
        exp_bits[7] = tx[1];
        exp_bits[8] = tx[0];
        if (kd) begin
            for (int i = 1; i <= 4; i++) exp_bits[i] = 1'b0;
            exp_bits[5] = res; exp_bits[6] = ov;
        end else begin
            exp_bits[1] = fn[3]; exp_bits[2] = fn[2];
            exp_bits[3] = fn[1]; exp_bits[4] = fn[0];
            exp_bits[5] = lb;    exp_bits[6] = rp;
        end
        nph = md ? 2 : 3;
        @(negedge clk);
        kind_i = kd; func_i = fn; lowbat_i = lb; repeat_i = rp; txcnt_i = tx;
        result_i = res; ovwr_i = ov; sync_mode_i = md; send_i = 1'b1;
        @(negedge clk);
        send_i = 1'b0;
        cyc = 0;
        for (int b = 0; b < 10; b++) begin
            for (int e = 0; e < nph; e++) begin
                for (int c = 0; c < ELEM; c++) begin
                    if (cyc != 0) @(negedge clk);
                    if (md) begin
                        ed = exp_bits[b];
                        ec = (e == 0);
                    end else begin
                        ed = (e == 0) ? 1'b1 : (e == 1) ? ~exp_bits[b] : 1'b0;
                        ec = 1'b0;
                    end
                    chk(data_o, ed, $sformatf("%s %s%s bit%0d elem%0d data", tag,
                        (b == 0 || b == 9) ? "R3 " : "", md ? "R5" : "R4", b, e));
                    chk(clk_o, ec, $sformatf("%s %s bit%0d elem%0d clk", tag,
                        md ? "R5" : "R4", b, e));
                    chk(busy_o, 1'b1, $sformatf("%s R6 busy cycle %0d", tag, cyc));
                    // R7 / R9: strobe plus changed payload and mode mid-frame
                    send_i = (cyc == 5);
                    if (cyc == 5) begin
                        kind_i = ~kd; func_i = ~fn; lowbat_i = ~lb; repeat_i = ~rp;
                        txcnt_i = ~tx; result_i = ~res; ovwr_i = ~ov; sync_mode_i = ~md;
                    end
                    cyc++;
                end
            end
        end
        send_i = 1'b1;   // R7: strobe in the last busy cycle
        @(negedge clk);
        send_i = 1'b0;
        chk(busy_o, 1'b0, $sformatf("%s R6 busy ends after %0d cycles", tag, cyc));
        for (int k = 0; k < 3 * ELEM; k++) begin
            @(negedge clk);
            chk(busy_o, 1'b0, $sformatf("%s R7 no frame after late strobe", tag));
            chk(data_o, 1'b0, $sformatf("%s R8 idle data", tag));
            chk(clk_o,  1'b0, $sformatf("%s R8 idle clk", tag));
        end
    endtask

    initial begin
        check_reset();
        run_frame(1'b0, 4'b1010, 1'b1, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, "R1 evt pwm");
        run_frame(1'b0, 4'b0110, 1'b0, 1'b1, 2'b10, 1'b1, 1'b1, 1'b1, "R1 R9 evt sync");
        run_frame(1'b1, 4'b1111, 1'b1, 1'b1, 2'b11, 1'b1, 1'b0, 1'b0, "R2 stat pwm");
        run_frame(1'b1, 4'b1111, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 1'b1, "R2 R9 stat sync");
        run_frame(1'b0, 4'b0000, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, "R1 evt zeros pwm");
        run_frame(1'b0, 4'b1111, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0, 1'b1, "R1 evt ones sync");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule